// File: doc/BRIEF.md
# MDIO Management Engine

This block gives a host a small register interface for reading and writing PHY management registers over a two-wire serial link. It derives the management clock (MDC) from the system clock through one of seven even division ratios. It runs one transaction at a time on the MDIO line and reports that through a busy flag. The host first loads a target address, which holds a PHY number and a register number. It then either loads a 16-bit value, which starts a write at once, or sets the read bit of the command register, which starts a read. When busy falls, the result of a read is in the read-data register. The read bit stays set until the host clears it, and a new read needs a fresh 0-to-1 transition of that bit.

The divider index should be the smallest ratio that keeps MDC at or below the PHY's maximum frequency. Index 0 to 6 select ratios 4, 6, 8, 10, 14, 20 and 28. Index 7 also selects 28. MDC runs freely whenever the engine is out of soft reset. A frame has 64 MDC periods:

- 32 preamble ones
- start pattern 01
- opcode: 01 for a write, 10 for a read
- PHY number, 5 bits
- register number, 5 bits
- turnaround: 10 on a write
- 16 data bits, MSB first

Every field is shifted MSB first.

The frame state machine has these states and transitions:

- `ST_IDLE` goes to `ST_ARM` on a launch.
- `ST_ARM` waits for the next MDC falling edge. On that edge it drives the first bit and moves to `ST_PRE`.
- On each further falling edge the machine moves to the state that owns the next bit index: `ST_PRE`, `ST_HDR`, `ST_TURN` or `ST_DATA`.
- The falling edge that ends bit 63 leads to `ST_FIN`. That state loads the read result and then returns to `ST_IDLE`.

Busy is high in every state except `ST_IDLE`. If a data write and a read command arrive in the same cycle, the write is taken.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: MDC has a period of exactly 4, 6, 8, 10, 14, 20 or 28 system clocks for `cfg_div_sel` 0 to 6, and 28 for index 7. High time and low time are each half the period.
- R2: Out of reset, busy, MDC, `mdio_oe` and `rd_data` are 0. A `wdat_we` pulse while idle sets busy on the next clock edge. `mdio_oe` is low whenever busy is low.
- R3: A write frame, sampled at MDC rising edges, is 32 ones, then 01, 01, `addr_wdata[9:5]` (PHY), `addr_wdata[4:0]` (register), 10, and the 16 data bits MSB first. `mdio_oe` is high for all 64 bits.
- R4: `mdio_o` changes only on a system clock edge at which MDC falls.
- R5: A `cmd_we` with `cmd_rd`=1 while idle and while `rd_cmd_bit` is 0 starts a read frame. Its first 46 bits are 32 ones, 01, 10, PHY and register. `mdio_oe` is low from the turnaround bit (index 46) to the end of the frame.
- R6: During a read, `mdio_i` is sampled on the MDC rising edges of bits 48 to 63. The first sampled bit is the MSB. The 16-bit result is in `rd_data` when busy falls.
- R7: While busy, writes to the address, write-data and command registers are ignored. The frame in flight is unchanged, `rd_cmd_bit` is unchanged, and no further frame starts after it.
- R8: While `cfg_soft_rst` is 1, MDC is held at 0, busy and `mdio_oe` are 0, a frame in flight is abandoned, and launches are ignored. MDC runs again once the bit is cleared.
- R9: `rd_cmd_bit` holds its value until the host writes the command register. A further write with `cmd_rd`=1 while it is already 1 does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div_sel | input | 3 | MDC ratio index |
| cfg_soft_rst | input | 1 | Holds divider and frame logic in reset while 1 |
| addr_we | input | 1 | Address register write strobe |
| addr_wdata | input | 10 | [9:5] PHY number, [4:0] register number |
| wdat_we | input | 1 | Write-data strobe; starts a write frame |
| wdat_wdata | input | 16 | Value to write |
| cmd_we | input | 1 | Command register write strobe |
| cmd_rd | input | 1 | Read bit value written to the command register |
| rd_cmd_bit | output | 1 | Current read bit of the command register |
| rd_data | output | 16 | Result of the last read |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench checks the ratio table at both ends and at index 7, where an off-by-one divider would stretch or shorten every half period. It captures whole frames at MDC rising edges and returns read data from a PHY model, so these errors show up:

- a misplaced turnaround release or opcode
- read bits sampled on the wrong edge, which would shift `rd_data` by one
- an output that moves on a rising edge

Register writes made in the middle of a frame show whether the design corrupts the frame in flight or queues a second frame. A read bit set while it is already set shows whether the design retriggers on level instead of on the transition. A soft reset in the middle of a frame must stop MDC and clear busy, not let the frame run on.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_PRE,
        ST_HDR,
        ST_TURN,
        ST_DATA,
        ST_FIN
    } mgmt_state_t;

    // Half of the MDC ratio for each index; ratios 4,6,8,10,14,20,28.
    function automatic logic [4:0] half_ratio(input logic [2:0] idx);
        logic [4:0] h;
        case (idx)
            3'd0:    h = 5'd2;
            3'd1:    h = 5'd3;
            3'd2:    h = 5'd4;
            3'd3:    h = 5'd5;
            3'd4:    h = 5'd7;
            3'd5:    h = 5'd10;
            default: h = 5'd14;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
    import mdio_mgmt_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic [SEL_W-1:0] div_sel,
    output logic             mdc,
    output logic             mdc_rise,
    output logic             mdc_fall
);

    logic [CNT_W-1:0] cnt_q;
    logic             mdc_q;
    logic [CNT_W-1:0] lim;
    logic             toggle;

    assign lim    = CNT_W'(half_ratio(3'(div_sel)) - 5'd1);
    // >= keeps the counter bounded when the ratio shrinks mid-count
    assign toggle = (cnt_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (soft_clr) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (toggle) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign mdc      = mdc_q;
    assign mdc_rise = toggle & ~mdc_q & ~soft_clr;
    assign mdc_fall = toggle &  mdc_q & ~soft_clr;

endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs #(
    parameter int PHY_AW = 5,
    parameter int REG_AW = 5,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     soft_clr,
    input  logic                     busy,
    input  logic                     addr_we,
    input  logic [PHY_AW+REG_AW-1:0] addr_wdata,
    input  logic                     wdat_we,
    input  logic [DATA_W-1:0]        wdat_wdata,
    input  logic                     cmd_we,
    input  logic                     cmd_rd,
    input  logic                     rd_load,
    input  logic [DATA_W-1:0]        rd_value,
    output logic [PHY_AW-1:0]        phy_addr,
    output logic [REG_AW-1:0]        reg_addr,
    output logic [DATA_W-1:0]        tx_data,
    output logic                     go_write,
    output logic                     go_read,
    output logic                     rd_cmd_bit,
    output logic [DATA_W-1:0]        rd_data
);

    logic [PHY_AW+REG_AW-1:0] addr_q;
    logic                     rd_cmd_q;
    logic [DATA_W-1:0]        rd_data_q;
    logic                     accept;

    assign accept   = ~busy & ~soft_clr;
    assign go_write = wdat_we & accept;
    // write wins when both strobes land in one cycle
    assign go_read  = cmd_we & cmd_rd & ~rd_cmd_q & accept & ~wdat_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            rd_cmd_q  <= 1'b0;
            rd_data_q <= '0;
        end else begin
            if (addr_we && accept) addr_q   <= addr_wdata;
            if (cmd_we && accept)  rd_cmd_q <= cmd_rd;
            if (rd_load)           rd_data_q <= rd_value;
        end
    end

    assign phy_addr   = addr_q[PHY_AW+REG_AW-1:REG_AW];
    assign reg_addr   = addr_q[REG_AW-1:0];
    assign tx_data    = wdat_wdata;
    assign rd_cmd_bit = rd_cmd_q;
    assign rd_data    = rd_data_q;

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_mgmt_pkg::*;
#(
    parameter int PHY_AW  = 5,
    parameter int REG_AW  = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              mdc_rise,
    input  logic              mdc_fall,
    input  logic              go_write,
    input  logic              go_read,
    input  logic [PHY_AW-1:0] phy_addr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_load,
    output logic [DATA_W-1:0] rd_value
);

    localparam int HDR_LEN    = 4 + PHY_AW + REG_AW;
    localparam int FRAME_LEN  = PRE_LEN + HDR_LEN + 2 + DATA_W;
    localparam int IDX_W      = $clog2(FRAME_LEN);
    localparam int TA_FIRST   = PRE_LEN + HDR_LEN;
    localparam int DATA_FIRST = TA_FIRST + 2;
    localparam logic [IDX_W-1:0] HDR_I  = IDX_W'(PRE_LEN);
    localparam logic [IDX_W-1:0] TA_I   = IDX_W'(TA_FIRST);
    localparam logic [IDX_W-1:0] DATA_I = IDX_W'(DATA_FIRST);
    localparam logic [IDX_W-1:0] LAST_I = IDX_W'(FRAME_LEN - 1);

    mgmt_state_t            state_q, state_d;
    logic [IDX_W-1:0]       bit_idx_q;
    logic [IDX_W-1:0]       nxt_idx;
    logic [FRAME_LEN-1:0]   frame_q;
    logic                   is_rd_q;
    logic [DATA_W-1:0]      rx_q;
    logic                   mdio_o_q;
    logic                   mdio_oe_q;
    logic                   rd_load_q;

    assign nxt_idx = bit_idx_q + IDX_W'(1);

    function automatic mgmt_state_t region_of(input logic [IDX_W-1:0] idx);
        if (idx < HDR_I)       return ST_PRE;
        else if (idx < TA_I)   return ST_HDR;
        else if (idx < DATA_I) return ST_TURN;
        else                   return ST_DATA;
    endfunction

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go_write || go_read) state_d = ST_ARM;
            ST_ARM:  if (mdc_fall) state_d = ST_PRE;
            ST_PRE, ST_HDR, ST_TURN, ST_DATA: begin
                if (mdc_fall) begin
                    if (bit_idx_q == LAST_I) state_d = ST_FIN;
                    else                     state_d = region_of(nxt_idx);
                end
            end
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= ST_IDLE;
        else if (soft_clr) state_q <= ST_IDLE;
        else               state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx_q <= '0;
            frame_q   <= '0;
            is_rd_q   <= 1'b0;
            rx_q      <= '0;
            mdio_o_q  <= 1'b1;
            mdio_oe_q <= 1'b0;
            rd_load_q <= 1'b0;
        end else if (soft_clr) begin
            bit_idx_q <= '0;
            frame_q   <= '0;
            is_rd_q   <= 1'b0;
            rx_q      <= '0;
            mdio_o_q  <= 1'b1;
            mdio_oe_q <= 1'b0;
            rd_load_q <= 1'b0;
        end else begin
            rd_load_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (go_write || go_read) begin
                        is_rd_q <= ~go_write;
                        frame_q <= {{PRE_LEN{1'b1}}, 2'b01,
                                    go_write ? 2'b01 : 2'b10,
                                    phy_addr, reg_addr,
                                    go_write ? 2'b10 : 2'b11,
                                    go_write ? tx_data : {DATA_W{1'b0}}};
                    end
                end
                ST_ARM: begin
                    if (mdc_fall) begin
                        bit_idx_q <= '0;
                        mdio_o_q  <= frame_q[FRAME_LEN-1];
                        frame_q   <= frame_q << 1;
                        mdio_oe_q <= 1'b1;
                    end
                end
                ST_PRE, ST_HDR, ST_TURN, ST_DATA: begin
                    if (mdc_rise && state_q == ST_DATA) begin
                        rx_q <= {rx_q[DATA_W-2:0], mdio_i};
                    end
                    if (mdc_fall) begin
                        if (bit_idx_q == LAST_I) begin
                            mdio_o_q  <= 1'b1;
                            mdio_oe_q <= 1'b0;
                            rd_load_q <= is_rd_q;
                        end else begin
                            bit_idx_q <= nxt_idx;
                            mdio_o_q  <= frame_q[FRAME_LEN-1];
                            frame_q   <= frame_q << 1;
                            mdio_oe_q <= ~is_rd_q | (nxt_idx < TA_I);
                        end
                    end
                end
                ST_FIN: begin
                end
                default: begin
                end
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign mdio_o   = mdio_o_q;
    assign mdio_oe  = mdio_oe_q;
    assign rd_load  = rd_load_q;
    assign rd_value = rx_q;

endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine #(
    parameter int PHY_AW  = 5,
    parameter int REG_AW  = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32,
    parameter int SEL_W   = 3,
    parameter int CNT_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SEL_W-1:0]         cfg_div_sel,
    input  logic                     cfg_soft_rst,
    input  logic                     addr_we,
    input  logic [PHY_AW+REG_AW-1:0] addr_wdata,
    input  logic                     wdat_we,
    input  logic [DATA_W-1:0]        wdat_wdata,
    input  logic                     cmd_we,
    input  logic                     cmd_rd,
    output logic                     rd_cmd_bit,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     busy,
    output logic                     mdc,
    output logic                     mdio_o,
    output logic                     mdio_oe,
    input  logic                     mdio_i
);

    logic              mdc_rise, mdc_fall;
    logic              go_write, go_read;
    logic [PHY_AW-1:0] phy_addr;
    logic [REG_AW-1:0] reg_addr;
    logic [DATA_W-1:0] tx_data;
    logic              rd_load;
    logic [DATA_W-1:0] rd_value;

    mdio_mdc_gen #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (cfg_soft_rst),
        .div_sel  (cfg_div_sel),
        .mdc      (mdc),
        .mdc_rise (mdc_rise),
        .mdc_fall (mdc_fall)
    );

    mdio_host_regs #(.PHY_AW(PHY_AW), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_clr   (cfg_soft_rst),
        .busy       (busy),
        .addr_we    (addr_we),
        .addr_wdata (addr_wdata),
        .wdat_we    (wdat_we),
        .wdat_wdata (wdat_wdata),
        .cmd_we     (cmd_we),
        .cmd_rd     (cmd_rd),
        .rd_load    (rd_load),
        .rd_value   (rd_value),
        .phy_addr   (phy_addr),
        .reg_addr   (reg_addr),
        .tx_data    (tx_data),
        .go_write   (go_write),
        .go_read    (go_read),
        .rd_cmd_bit (rd_cmd_bit),
        .rd_data    (rd_data)
    );

    mdio_frame_fsm #(.PHY_AW(PHY_AW), .REG_AW(REG_AW), .DATA_W(DATA_W),
                     .PRE_LEN(PRE_LEN)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (cfg_soft_rst),
        .mdc_rise (mdc_rise),
        .mdc_fall (mdc_fall),
        .go_write (go_write),
        .go_read  (go_read),
        .phy_addr (phy_addr),
        .reg_addr (reg_addr),
        .tx_data  (tx_data),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_load  (rd_load),
        .rd_value (rd_value)
    );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_soft_rst,
    input logic wdat_we,
    input logic cmd_we,
    input logic rd_cmd_bit,
    input logic busy,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);

    p_launch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wdat_we && !busy && !cfg_soft_rst) |=> busy);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    p_mdio_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n || cfg_soft_rst)
        (!$stable(mdio_o) && !$past(cfg_soft_rst)) |-> ($past(mdc) && !mdc));

    p_soft_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_soft_rst |=> (!mdc && !busy && !mdio_oe));

    p_rdcmd_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd_bit && !cmd_we) |=> rd_cmd_bit);

endmodule

bind mdio_mgmt_engine mdio_mgmt_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_soft_rst (cfg_soft_rst),
    .wdat_we      (wdat_we),
    .cmd_we       (cmd_we),
    .rd_cmd_bit   (rd_cmd_bit),
    .busy         (busy),
    .mdc          (mdc),
    .mdio_o       (mdio_o),
    .mdio_oe      (mdio_oe)
);

// File: tb/mdio_mgmt_engine_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_div_sel = 3'd0;
    logic        cfg_soft_rst = 1'b0;
    logic        addr_we = 1'b0;
    logic [9:0]  addr_wdata = '0;
    logic        wdat_we = 1'b0;
    logic [15:0] wdat_wdata = '0;
    logic        cmd_we = 1'b0;
    logic        cmd_rd = 1'b0;
    logic        rd_cmd_bit;
    logic [15:0] rd_data;
    logic        busy, mdc, mdio_o, mdio_oe;
    logic        phy_drive = 1'b1;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mdio_mgmt_engine u_mdio_mgmt_engine (
        .clk(clk), .rst_n(rst_n), .cfg_div_sel(cfg_div_sel), .cfg_soft_rst(cfg_soft_rst),
        .addr_we(addr_we), .addr_wdata(addr_wdata), .wdat_we(wdat_we), .wdat_wdata(wdat_wdata),
        .cmd_we(cmd_we), .cmd_rd(cmd_rd), .rd_cmd_bit(rd_cmd_bit), .rd_data(rd_data),
        .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(phy_drive)
    );

    // monitor and PHY model
    logic [63:0] cap_bits, cap_oe;
    int          k = 0;
    bit          recording = 0;
    logic [15:0] rdval = '0;
    logic        prev_mdc = 0, prev_mdio = 1, prev_srst = 0;
    int          r4_viol = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mdio_o != prev_mdio && !(prev_mdc && !mdc) && !cfg_soft_rst && !prev_srst)
                r4_viol++;
            if (!prev_mdc && mdc && (recording || mdio_oe) && busy && k < 64) begin
                cap_bits[63-k] = mdio_o;
                cap_oe[63-k]   = mdio_oe;
                k++;
                recording = 1;
            end
            if (prev_mdc && !mdc && recording)
                phy_drive = (k >= 48 && k <= 63) ? rdval[63-k] : 1'b1;
        end
        prev_mdc  = mdc;
        prev_mdio = mdio_o;
        prev_srst = cfg_soft_rst;
    end

    function automatic int ratio_of(input int idx);
        case (idx)
            0: return 4;  1: return 6;  2: return 8;  3: return 10;
            4: return 14; 5: return 20; default: return 28;
        endcase
    endfunction

    function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg,
                rd ? 2'b11 : 2'b10, rd ? 16'h0 : d};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reset_capture();
        k = 0; recording = 0; cap_bits = '0; cap_oe = '0; phy_drive = 1'b1;
    endtask

    task automatic set_addr(input logic [4:0] phy, input logic [4:0] rg);
        @(negedge clk); addr_we = 1; addr_wdata = {phy, rg};
        @(negedge clk); addr_we = 0;
    endtask

    task automatic pulse_wdat(input logic [15:0] d);
        @(negedge clk); wdat_we = 1; wdat_wdata = d;
        @(negedge clk); wdat_we = 0;
    endtask

    task automatic pulse_cmd(input bit rd);
        @(negedge clk); cmd_we = 1; cmd_rd = rd;
        @(negedge clk); cmd_we = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic do_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d,
                            input string tag);
        set_addr(phy, rg);
        reset_capture();
        pulse_wdat(d);
        chk(busy === 1'b1, {tag, " R2 busy after launch"}, 64'(busy), 64'd1);
        wait_idle();
        chk(cap_bits === exp_frame(0, phy, rg, d) && k == 64, {tag, " R3 write frame"},
            cap_bits, exp_frame(0, phy, rg, d));
        chk(cap_oe === {64{1'b1}}, {tag, " R3 write oe"}, cap_oe, {64{1'b1}});
    endtask

    task automatic do_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] v,
                           input string tag);
        logic [63:0] ef;
        set_addr(phy, rg);
        reset_capture();
        rdval = v;
        pulse_cmd(1);
        wait_idle();
        ef = exp_frame(1, phy, rg, 16'h0);
        chk(cap_bits[63:18] === ef[63:18] && k == 64, {tag, " R5 read header"},
            {18'h0, cap_bits[63:18]}, {18'h0, ef[63:18]});
        chk(cap_oe === {{46{1'b1}}, 18'h0}, {tag, " R5 read release"}, cap_oe, {{46{1'b1}}, 18'h0});
        chk(rd_data === v, {tag, " R6 read data"}, 64'(rd_data), 64'(v));
        pulse_cmd(0);
    endtask

    task automatic measure(input int idx);
        int hi, lo;
        cfg_div_sel = 3'(idx);
        repeat (80) @(negedge clk);
        @(posedge mdc);
        @(negedge clk);
        hi = 0;
        while (mdc) begin hi++; @(negedge clk); end
        lo = 0;
        while (!mdc) begin lo++; @(negedge clk); end
        chk(hi + lo == ratio_of(idx) && hi == ratio_of(idx) / 2, "R1 MDC period",
            64'((hi << 8) | lo), 64'(((ratio_of(idx) / 2) << 8) | (ratio_of(idx) / 2)));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R2 reset state
        chk(busy === 0 && mdc === 0 && mdio_oe === 0 && rd_data === 16'h0, "R2 reset state",
            {44'h0, busy, mdc, mdio_oe, 1'b0, rd_data}, 64'h0);

        // R1 ratio table including the alias index 7
        for (int i = 0; i < 8; i++) measure(i);

        // R3 directed writes
        cfg_div_sel = 3'd0;
        do_write(5'h1F, 5'h00, 16'hA5C3, "dir1");
        do_write(5'h00, 5'h1F, 16'h0001, "dir2");

        // R7 writes during busy are ignored
        set_addr(5'h0A, 5'h15);
        reset_capture();
        pulse_wdat(16'h1234);
        repeat (60) @(negedge clk);
        @(negedge clk); addr_we = 1; addr_wdata = 10'h3FF; @(negedge clk); addr_we = 0;
        pulse_wdat(16'hFFFF);
        pulse_cmd(1);
        wait_idle();
        chk(cap_bits === exp_frame(0, 5'h0A, 5'h15, 16'h1234), "R7 frame unchanged by busy writes",
            cap_bits, exp_frame(0, 5'h0A, 5'h15, 16'h1234));
        chk(rd_cmd_bit === 1'b0, "R7 command ignored while busy", 64'(rd_cmd_bit), 64'd0);
        begin
            bit seen = 0;
            repeat (200) begin @(negedge clk); if (busy) seen = 1; end
            chk(!seen, "R7 no queued frame", 64'(seen), 64'd0);
        end

        // R5 R6 directed reads
        do_read(5'h03, 5'h02, 16'h8001, "dir1");
        do_read(5'h1C, 5'h11, 16'h7FFE, "dir2");

        // R9 read bit held; retrigger while set does nothing
        pulse_cmd(1);
        wait_idle();
        chk(rd_cmd_bit === 1'b1, "R9 read bit stays set", 64'(rd_cmd_bit), 64'd1);
        pulse_cmd(1);
        begin
            bit seen = 0;
            repeat (100) begin @(negedge clk); if (busy) seen = 1; end
            chk(!seen && rd_cmd_bit === 1'b1, "R9 no relaunch while set", 64'(seen), 64'd0);
        end
        pulse_cmd(0);
        chk(rd_cmd_bit === 1'b0, "R9 read bit cleared", 64'(rd_cmd_bit), 64'd0);

        // R8 soft reset mid-frame
        pulse_wdat(16'hBEEF);
        repeat (100) @(negedge clk);
        cfg_soft_rst = 1;
        repeat (2) @(negedge clk);
        chk(busy === 0 && mdc === 0 && mdio_oe === 0, "R8 soft reset clears",
            {61'h0, busy, mdc, mdio_oe}, 64'h0);
        pulse_wdat(16'h5555);
        begin
            bit seen = 0;
            repeat (100) begin @(negedge clk); if (busy || mdc) seen = 1; end
            chk(!seen, "R8 held while soft reset", 64'(seen), 64'd0);
        end
        cfg_soft_rst = 0;
        begin
            bit seen = 0;
            repeat (20) begin @(negedge clk); if (mdc) seen = 1; end
            chk(seen, "R8 MDC resumes", 64'(seen), 64'd1);
        end
        reset_capture();

        // constrained random mix
        for (int n = 0; n < 12; n++) begin
            logic [4:0]  p, r;
            logic [15:0] d;
            cfg_div_sel = 3'($urandom % 7);
            p = 5'($urandom);
            r = 5'($urandom);
            d = 16'($urandom);
            if ($urandom % 2) do_read(p, r, d, "rnd");
            else              do_write(p, r, d, "rnd");
        end

        chk(r4_viol == 0, "R4 MDIO moves only on MDC fall", 64'(r4_viol), 64'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule